// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block remaps client addresses that land inside a fixed aperture window onto physical memory, one 4 KiB page at a time. It keeps a single-level table with one 32-bit entry per aperture page. In each entry, bit 31 marks the page as mapped and bits 30:12 carry the physical frame number. A lookup port takes a client address and, one cycle later, returns either the translated physical address or a fault.

Software maintains the table through a small register port that reaches entries indirectly. It first writes a full aperture byte address into a selector register. It then writes or reads the data register, which acts on the entry that the selector picks. A configuration register holds the global enable. While translation is disabled, every lookup faults. Reads of the register port answer one cycle after the strobe. A read therefore always observes every write issued in an earlier cycle, so software can read the configuration register to make sure its earlier writes have landed.

The aperture base address and the number of pages are parameters.

Top module: `aperture_remap`

## Requirements
- R1: After reset, the configuration register reads 0, every table entry reads 0, and every lookup faults.
- R2: Register offset 0x0 is the configuration register. A write stores wdata bit 0 as the enable. A read returns {31'b0, enable}. Every read strobe produces reg_rd_ack and reg_rdata in the following cycle.
- R3: Register offset 0x4 is the entry selector. It stores all 32 written bits and reads them back. The selected entry index is (selector − base) >> 12, so selector bits 11:0 do not affect which entry is chosen.
- R4: Register offset 0x8 is the entry data port. A write stores all 32 bits into the selected entry. A read returns the selected entry's contents.
- R5: When the selector holds an address outside [base, base + pages·4096), a write to the data port changes no entry, and a read of the data port returns 0.
- R6: Each lookup request produces lk_valid in the next cycle. If translation is enabled, the address is inside the aperture and the entry has bit 31 set, the result is lk_fault = 0 and lk_pa = {1'b0, entry[30:12], addr[11:0]}.
- R7: A lookup outside the aperture sets lk_fault with lk_pa = 0, whatever the enable state.
- R8: A lookup that hits an entry with bit 31 clear sets lk_fault with lk_pa = 0.
- R9: While the enable is 0, every lookup inside the aperture sets lk_fault with lk_pa = 0.
- R10: When an entry data write and a lookup of the same entry occur in the same cycle, the lookup returns the translation from the entry's old value. The next lookup uses the new value.
- R11: Offsets other than 0x0, 0x4 and 0x8 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rd_ack |
| reg_rd_ack | output | 1 | Read answered, one cycle after reg_rd_en |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Client address to translate |
| lk_valid | output | 1 | Lookup result valid, one cycle after lk_req |
| lk_pa | output | 32 | Translated physical address, 0 on fault |
| lk_fault | output | 1 | Lookup faulted |

## Verification
The assertions assume that lk_addr and the register inputs carry known values whenever their strobes are high. They also assume that the enable seen by the checker is the one held in the cycle of the request, which means a configuration write in the same cycle as a lookup is not covered. The bench drives the strobes from tasks, one operation per cycle, and always presents defined values. The only deliberate overlap is the single cycle in which a data write and a lookup of the same entry are issued together. The configuration register is never written in that cycle.

// File: rtl/aprt_pkg.sv
// Package: shared constants and types for the aperture remapping table.
// Assumes a 4-bit register offset and 32-bit table entries.
package aprt_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int REG_AW     = 4;

    typedef logic [REG_AW-1:0] reg_off_t;

    localparam reg_off_t OFF_CFG   = 4'h0;
    localparam reg_off_t OFF_EADDR = 4'h4;
    localparam reg_off_t OFF_EDATA = 4'h8;

    // Layout of one table entry.
    typedef struct packed {
        logic        valid;
        logic [18:0] pfn;
        logic [11:0] rsvd;
    } pte_t;
endpackage

// File: rtl/aprt_decode.sv
// Module: aperture window check and entry index for one byte address.
// Assumes BASE is 4 KiB aligned and the window fits below 2^32.
module aprt_decode #(
    parameter logic [31:0] BASE       = 32'h4000_0000,
    parameter int          PAGE_COUNT = 16,
    parameter int          IDX_W      = 4
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [32:0] APER_BYTES = 33'(PAGE_COUNT) << aprt_pkg::PAGE_SHIFT;

    // Window membership and page index, purely combinational.
    always_comb begin
        hit = (addr >= BASE) && ((33'(addr) - 33'(BASE)) < APER_BYTES);
        idx = IDX_W'((addr - BASE) >> aprt_pkg::PAGE_SHIFT);
    end
endmodule

// File: rtl/aprt_table.sv
// Module: entry storage with one write port and two combinational read ports.
// Port A serves the register port. Port B serves lookups and returns only the valid bit and the frame.
// Assumes that indices come from aprt_decode and that callers gate the reads with its hit flag.
module aprt_table #(
    parameter int PAGE_COUNT = 16,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output logic [31:0]      rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output logic [19:0]      rdata_b
);
    aprt_pkg::pte_t tab [PAGE_COUNT];

    // Clear all entries on reset, otherwise store one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_COUNT; i++) tab[i] <= '0;
        end else if (we) begin
            tab[widx] <= aprt_pkg::pte_t'(wdata);
        end
    end

    // Read ports return the stored value that precedes this cycle's write.
    always_comb begin
        rdata_a = tab[ridx_a];
        rdata_b = {tab[ridx_b].valid, tab[ridx_b].pfn};
    end
endmodule

// File: rtl/aprt_regs.sv
// Module: register port holding the enable, the entry selector and the read-data mux.
// Assumes at most one read and one write per cycle. A read returns the state before the same cycle's write.
module aprt_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  off,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        rd_ack,
    output logic        cfg_en,
    output logic [31:0] eaddr,
    input  logic        ehit,
    input  logic [31:0] tab_rdata,
    output logic        tab_we
);
    import aprt_pkg::*;

    logic [31:0] rd_mux;

    // Store the enable bit and the entry selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en <= 1'b0;
            eaddr  <= '0;
        end else if (wr_en) begin
            if (off == OFF_CFG)   cfg_en <= wdata[0];
            if (off == OFF_EADDR) eaddr  <= wdata;
        end
    end

    // An entry write only goes ahead when the selector lies in the window.
    always_comb tab_we = wr_en && (off == OFF_EDATA) && ehit;

    // Pick the read value by offset.
    always_comb begin
        unique case (off)
            OFF_CFG:   rd_mux = {31'b0, cfg_en};
            OFF_EADDR: rd_mux = eaddr;
            OFF_EDATA: rd_mux = ehit ? tab_rdata : 32'h0;
            default:   rd_mux = 32'h0;
        endcase
    end

    // Register the read answer one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ack <= 1'b0;
            rdata  <= '0;
        end else begin
            rd_ack <= rd_en;
            rdata  <= rd_en ? rd_mux : 32'h0;
        end
    end
endmodule

// File: rtl/aprt_xlate.sv
// Module: registered lookup stage that forms the physical address or a fault.
// Assumes hit, the entry fields and the enable all describe the cycle of the request.
module aprt_xlate (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [11:0] page_off,
    input  logic        hit,
    input  logic        en,
    input  logic        ent_valid,
    input  logic [18:0] ent_pfn,
    output logic        valid,
    output logic [31:0] pa,
    output logic        fault
);
    // Produce one result per request, with a zero address on any fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            pa    <= '0;
            fault <= 1'b0;
        end else begin
            valid <= req;
            if (req && hit && en && ent_valid) begin
                pa    <= {1'b0, ent_pfn, page_off};
                fault <= 1'b0;
            end else begin
                pa    <= '0;
                fault <= req;
            end
        end
    end
endmodule

// File: rtl/aperture_remap.sv
// Module: top of the aperture page remapping table.
// It joins the register port, the table, two window decoders and the lookup stage.
// Assumes BASE is page aligned and PAGE_COUNT >= 2.
module aperture_remap #(
    parameter logic [31:0] BASE       = 32'h4000_0000,
    parameter int          PAGE_COUNT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rd_ack,
    input  logic        lk_req,
    input  logic [31:0] lk_addr,
    output logic        lk_valid,
    output logic [31:0] lk_pa,
    output logic        lk_fault
);
    localparam int IDX_W = $clog2(PAGE_COUNT);

    logic             cfg_en;
    logic [31:0]      eaddr;
    logic             ehit, lhit, tab_we;
    logic [IDX_W-1:0] eidx, lidx;
    logic [31:0]      tab_rd_a;
    logic [19:0]      tab_rd_b;

    aprt_decode #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_dec_sel (
        .addr(eaddr), .hit(ehit), .idx(eidx)
    );

    aprt_decode #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_dec_lk (
        .addr(lk_addr), .hit(lhit), .idx(lidx)
    );

    aprt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
        .off(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata), .rd_ack(reg_rd_ack),
        .cfg_en(cfg_en), .eaddr(eaddr), .ehit(ehit), .tab_rdata(tab_rd_a),
        .tab_we(tab_we)
    );

    aprt_table #(.PAGE_COUNT(PAGE_COUNT), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tab_we), .widx(eidx), .wdata(reg_wdata),
        .ridx_a(eidx), .rdata_a(tab_rd_a), .ridx_b(lidx), .rdata_b(tab_rd_b)
    );

    aprt_xlate u_xlate (
        .clk(clk), .rst_n(rst_n), .req(lk_req), .page_off(lk_addr[11:0]),
        .hit(lhit), .en(cfg_en), .ent_valid(tab_rd_b[19]), .ent_pfn(tab_rd_b[18:0]),
        .valid(lk_valid), .pa(lk_pa), .fault(lk_fault)
    );
endmodule

// File: rtl/aprt_chk.sv
// Module: property checker, attached to aperture_remap by bind.
// Assumes the inputs are known whenever their strobes are high.
module aprt_chk #(
    parameter logic [31:0] BASE       = 32'h4000_0000,
    parameter int          PAGE_COUNT = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic        reg_rd_en,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        reg_rd_ack,
    input logic        lk_req,
    input logic [31:0] lk_addr,
    input logic        lk_valid,
    input logic [31:0] lk_pa,
    input logic        lk_fault,
    input logic        cfg_en
);
    localparam logic [32:0] SPAN = 33'(PAGE_COUNT) << 12;

    logic chk_in;

    // Window membership of the lookup address, computed independently of the decoders.
    always_comb chk_in = (33'(lk_addr) >= 33'(BASE)) && (33'(lk_addr) < 33'(BASE) + SPAN);

    AST_RD_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n) reg_rd_en |=> reg_rd_ack); // R2
    AST_RD_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !reg_rd_en |=> !reg_rd_ack); // R2
    AST_CFG_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && reg_addr == 4'h0) |=> (cfg_en == $past(reg_wdata[0]))); // R2
    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> lk_valid); // R6
    AST_LK_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |-> (lk_pa == 32'h0 && !lk_fault)); // R6
    AST_PA_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |-> !lk_pa[31]); // R6
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> (lk_fault || lk_pa[11:0] == $past(lk_addr[11:0]))); // R6
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) lk_fault |-> (lk_pa == 32'h0)); // R8
    AST_OUTSIDE_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (lk_req && !chk_in) |=> lk_fault); // R7
    AST_DISABLED_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (lk_req && !cfg_en) |=> lk_fault); // R9
endmodule

bind aperture_remap aprt_chk #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_ack(reg_rd_ack),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_valid(lk_valid), .lk_pa(lk_pa),
    .lk_fault(lk_fault), .cfg_en(cfg_en)
);

// File: tb/aperture_remap_tb.sv
// Bench: sweeps every page of a 16-page aperture and checks against a model
// that the bench computes from the requirements.
module aperture_remap_tb;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam int          PAGES = 16;
    localparam logic [31:0] ENDA  = BASE + 32'(PAGES) * 32'd4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rd_ack;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_valid;
    logic [31:0] lk_pa;
    logic        lk_fault;

    int          n_chk = 0, n_bad = 0;
    logic [31:0] model [PAGES];
    logic        model_en = 1'b0;

    always #2 clk = ~clk;

    aperture_remap #(.BASE(BASE), .PAGE_COUNT(PAGES)) u_dut (.*);

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one register write.
    task automatic wr(input logic [3:0] off, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Issue one register read and return the answer in the next cycle.
    task automatic rd(input logic [3:0] off, output logic [31:0] d, output logic ack);
        reg_rd_en = 1'b1; reg_addr = off;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata; ack = reg_rd_ack;
    endtask

    // Issue one lookup and return {valid, fault, pa} from the next cycle.
    task automatic lk(input logic [31:0] a, output logic [33:0] r);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
        r = {lk_valid, lk_fault, lk_pa};
    endtask

    // Expected lookup result derived from the requirements.
    function automatic logic [33:0] expect_lk(input logic [31:0] a);
        logic [31:0] e;
        if (a < BASE || a >= ENDA) return {2'b11, 32'h0};
        e = model[(a - BASE) >> 12];
        if (!model_en || !e[31]) return {2'b11, 32'h0};
        return {2'b10, 1'b0, e[30:12], a[11:0]};
    endfunction

    initial begin : main
        logic [31:0] d;
        logic        ack;
        logic [33:0] r;
        logic [31:0] v;
        for (int i = 0; i < PAGES; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        rd(4'h0, d, ack); check("R1 cfg after reset", d, 32'h0); check("R2 ack", {31'b0, ack}, 32'h1);
        for (int i = 0; i < PAGES; i++) begin
            wr(4'h4, BASE + 32'(i) * 32'd4096);
            rd(4'h8, d, ack); check("R1 entry after reset", d, 32'h0);
            lk(BASE + 32'(i) * 32'd4096 + 32'h10, r); check("R1 lookup faults after reset", r[31:0] | {30'b0, r[33:32]}, 32'h3);
        end

        // The selector reads back all 32 bits.
        wr(4'h4, BASE + 32'h3123);
        rd(4'h4, d, ack); check("R3 selector readback", d, BASE + 32'h3123);

        // Program every page, with nonzero selector bits 11:0.
        for (int i = 0; i < PAGES; i++) begin
            v = {(i % 5 != 3), 19'(i * 32'h1357 + 32'h21), 12'(i * 32'h11)};
            model[i] = v;
            wr(4'h4, BASE + 32'(i) * 32'd4096 + 32'((i * 32'h53) & 32'hfff));
            wr(4'h8, v);
        end
        for (int i = 0; i < PAGES; i++) begin
            wr(4'h4, BASE + 32'(i) * 32'd4096 + 32'hfff);
            rd(4'h8, d, ack); check("R4/R3 entry readback", d, model[i]);
        end

        // Enable. Only bit 0 of the write is kept.
        wr(4'h0, 32'h0000_0003); model_en = 1'b1;
        rd(4'h0, d, ack); check("R2 cfg readback", d, 32'h1);

        // Translation sweep over every page at three in-page offsets.
        for (int i = 0; i < PAGES; i++) begin
            for (int k = 0; k < 3; k++) begin
                v = BASE + 32'(i) * 32'd4096 + ((k == 0) ? 32'h0 : (k == 1) ? 32'h7ff : 32'hfff);
                lk(v, r);
                check(model[i][31] ? "R6 translate" : "R8 invalid entry", r[31:0], expect_lk(v)[31:0]);
                check("R6/R8 valid+fault", {30'b0, r[33:32]}, {30'b0, expect_lk(v)[33:32]});
            end
        end

        // Lookups outside the window.
        for (int k = 0; k < 5; k++) begin
            v = (k == 0) ? BASE - 32'h1 : (k == 1) ? BASE - 32'h1000 : (k == 2) ? ENDA :
                (k == 3) ? ENDA + 32'h10 : 32'h0;
            lk(v, r); check("R7 outside aperture", r[31:0] | {30'b0, r[33:32]}, 32'h3);
        end

        // Selector outside the window: the data write is dropped and the read returns 0.
        wr(4'h4, ENDA);
        wr(4'h8, 32'hffff_ffff);
        rd(4'h8, d, ack); check("R5 outside read zero", d, 32'h0);
        wr(4'h4, BASE - 32'h1000);
        wr(4'h8, 32'hffff_ffff);
        for (int i = 0; i < PAGES; i++) begin
            wr(4'h4, BASE + 32'(i) * 32'd4096);
            rd(4'h8, d, ack); check("R5 entries untouched", d, model[i]);
        end

        // Offset 0xC: reads 0, and a write leaves the other registers unchanged.
        wr(4'h4, BASE + 32'h2000);
        wr(4'hC, 32'hffff_ffff);
        rd(4'hC, d, ack); check("R11 unknown offset reads 0", d, 32'h0);
        rd(4'h0, d, ack); check("R11 cfg unchanged", d, 32'h1);
        rd(4'h4, d, ack); check("R11 selector unchanged", d, BASE + 32'h2000);

        // Data write and lookup of page 2 in the same cycle.
        v = {1'b1, 19'h5_a5a5, 12'h0};
        reg_wr_en = 1'b1; reg_addr = 4'h8; reg_wdata = v;
        lk_req = 1'b1; lk_addr = BASE + 32'h2abc;
        @(negedge clk);
        reg_wr_en = 1'b0; lk_req = 1'b0;
        r = {lk_valid, lk_fault, lk_pa};
        check("R10 lookup sees old entry", r[31:0], expect_lk(BASE + 32'h2abc)[31:0]);
        model[2] = v;
        lk(BASE + 32'h2abc, r); check("R10 next lookup sees new entry", r[31:0], {1'b0, 19'h5_a5a5, 12'habc});

        // Disable: every in-window lookup faults.
        wr(4'h0, 32'h0); model_en = 1'b0;
        rd(4'h0, d, ack); check("R2 cfg cleared", d, 32'h0);
        for (int i = 0; i < PAGES; i++) begin
            lk(BASE + 32'(i) * 32'd4096 + 32'h44, r);
            check("R9 disabled faults", r[31:0] | {30'b0, r[33:32]}, 32'h3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule